// File: doc/BRIEF.md
# Hit-Started Windowed Sample Capture

This block is the digital capture stage of one channel in a self-triggered detector readout. A 10-bit ADC sample is presented on every clock cycle whether or not anything is happening. When the channel's threshold discriminator reports a hit, together with a 10-bit arrival-time code, the block opens an acquisition window. It stores a programmable number of consecutive samples in a small local memory. It then drains a complete event record to a valid/ready output stream on its own. No trigger or readout request arrives from outside.

An event record is one header word carrying the arrival time and the sample count, followed by the stored samples in capture order. The final sample word carries a last marker. The output stream follows valid/ready rules. A word transfers on a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the word and its marker stay frozen, so back-pressure of any length loses nothing. The channel accepts no new hit while it is capturing or draining. Each rejected hit is tallied in a saturating counter that is visible as a plain status output.

Top module: `hitwin_capture`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `out_valid` low and `lost_count` at 0, with no window open, so the next hit is accepted.
- R2: A hit seen while idle opens a window. The sample present in the hit's own cycle is stored first, followed by the samples of the next consecutive cycles. Samples outside the window never appear in the output.
- R3: The window length is taken from `win_len` in the hit's cycle. Values 1 to 31 give that many samples and 0 gives 32. Changes to `win_len` while a window is open have no effect on that event.
- R4: The first word of a record has bit 16 set to 1, bits 15:6 holding the arrival-time code latched at the hit, and bits 5:0 holding the sample count (1 to 32). `out_last` is low on this word.
- R5: Each sample word has bit 16 at 0, bits 15:10 at 0 and bits 9:0 holding the sample, in capture order. `out_last` is high only on the final sample word.
- R6: `out_valid` stays low while the window is open. It goes high, with no request, in the cycle after the window's last sample is stored.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R8: A hit arriving while a window is open or a record is being drained is ignored and increments `lost_count` by one. The count stops at 255.
- R9: After the final word transfers, the block is idle. A hit in the very next cycle opens a new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock; one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 10 | Free-running ADC sample |
| hit | input | 1 | Discriminator threshold crossing |
| toa_in | input | 10 | Arrival-time code accompanying `hit` |
| win_len | input | 5 | Window length in samples; 0 means 32 |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 17 | Header or sample word |
| out_last | output | 1 | Marks the final word of a record |
| lost_count | output | 8 | Saturating count of rejected hits |

## Verification
The bench builds the block with its default parameters: 10-bit samples and arrival codes, a 32-entry memory and an 8-bit lost counter. At these values the full 32-sample window (selected by `win_len` of 0) and the one-sample window are both within reach. The counter saturation at 255 can also be reached within a single long stalled drain. Random window lengths, arrival codes, stray hits and ready patterns mix with directed cases. The directed cases cover the one-sample and full-depth windows, a length change in mid-window, a reset in mid-capture and a back-to-back hit right after the final transfer.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_DRAIN = 2'd2
  } cap_state_e;
endpackage

// File: rtl/hwc_sample_mem.sv
module hwc_sample_mem #(
  parameter int SAMPLE_W = 10,
  parameter int DEPTH    = 32,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]    rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);
  logic [SAMPLE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/hwc_ctrl.sv
module hwc_ctrl
  import hwc_pkg::*;
#(
  parameter int TOA_W  = 10,
  parameter int DEPTH  = 32,
  parameter int LOST_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [TOA_W-1:0]  toa_in,
  input  logic [PTR_W-1:0]  win_len,
  input  logic              drain_done,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic              capturing,
  output logic              draining,
  output logic [CNT_W-1:0]  ev_len,
  output logic [TOA_W-1:0]  ev_toa,
  output logic [LOST_W-1:0] lost_count
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  cap_state_e       state;
  logic [CNT_W-1:0] wr_ptr;
  logic [CNT_W-1:0] len_dec;
  logic             accept;

  assign len_dec = (win_len == '0) ? CNT_W'(DEPTH) : {1'b0, win_len};
  assign accept  = (state == ST_IDLE) && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wr_ptr <= '0;
      ev_len <= '0;
      ev_toa <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (hit) begin
          ev_toa <= toa_in;
          ev_len <= len_dec;
          wr_ptr <= CNT_W'(1);
          state  <= (len_dec == CNT_W'(1)) ? ST_DRAIN : ST_CAPT;
        end
        ST_CAPT: begin
          wr_ptr <= wr_ptr + CNT_W'(1);
          if (wr_ptr == ev_len - CNT_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: if (drain_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lost_count <= '0;
    else if (hit && (state != ST_IDLE) && (lost_count != LOST_MAX))
      lost_count <= lost_count + LOST_W'(1);
  end

  assign wr_en     = accept || (state == ST_CAPT);
  assign wr_addr   = accept ? '0 : wr_ptr[PTR_W-1:0];
  assign capturing = (state == ST_CAPT);
  assign draining  = (state == ST_DRAIN);
endmodule

// File: rtl/hwc_drain.sv
module hwc_drain #(
  parameter int SAMPLE_W = 10,
  parameter int TOA_W    = 10,
  parameter int DEPTH    = 32,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int OUT_W   = 1 + TOA_W + CNT_W,
  localparam int PAD_W   = OUT_W - 1 - SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic [CNT_W-1:0]    ev_len,
  input  logic [TOA_W-1:0]    ev_toa,
  input  logic [SAMPLE_W-1:0] rd_data,
  output logic [PTR_W-1:0]    rd_addr,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_last,
  output logic                drain_done
);
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] idx_m1;

  assign idx_m1     = idx - CNT_W'(1);
  assign rd_addr    = idx_m1[PTR_W-1:0];
  assign out_valid  = active;
  assign out_last   = active && (idx == ev_len);
  assign out_data   = (idx == '0) ? {1'b1, ev_toa, ev_len}
                                  : {1'b0, {PAD_W{1'b0}}, rd_data};
  assign drain_done = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (out_valid && out_ready) idx <= out_last ? '0 : idx + CNT_W'(1);
  end
endmodule

// File: rtl/hitwin_capture.sv
module hitwin_capture #(
  parameter int SAMPLE_W = 10,
  parameter int TOA_W    = 10,
  parameter int DEPTH    = 32,
  parameter int LOST_W   = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int OUT_W   = 1 + TOA_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                hit,
  input  logic [TOA_W-1:0]    toa_in,
  input  logic [PTR_W-1:0]    win_len,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_last,
  output logic [LOST_W-1:0]   lost_count
);
  logic                wr_en;
  logic [PTR_W-1:0]    wr_addr;
  logic [PTR_W-1:0]    rd_addr;
  logic [SAMPLE_W-1:0] rd_data;
  logic                capturing;
  logic                draining;
  logic                drain_done;
  logic [CNT_W-1:0]    ev_len;
  logic [TOA_W-1:0]    ev_toa;

  hwc_ctrl #(.TOA_W(TOA_W), .DEPTH(DEPTH), .LOST_W(LOST_W)) u_ctrl (
    .clk(clk), .rst(rst), .hit(hit), .toa_in(toa_in), .win_len(win_len),
    .drain_done(drain_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .capturing(capturing), .draining(draining), .ev_len(ev_len),
    .ev_toa(ev_toa), .lost_count(lost_count)
  );

  hwc_sample_mem #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(sample_in),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  hwc_drain #(.SAMPLE_W(SAMPLE_W), .TOA_W(TOA_W), .DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst(rst), .active(draining), .ev_len(ev_len),
    .ev_toa(ev_toa), .rd_data(rd_data), .rd_addr(rd_addr),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .drain_done(drain_done)
  );
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int OUT_W  = 17,
  parameter int LOST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_last,
  input logic [LOST_W-1:0] lost_count,
  input logic              capturing
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst ? 1'b1 : past_ok;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_lost_sat_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (lost_count == '1) |=> (lost_count == '1));

  assert_lost_step_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (lost_count != $past(lost_count)) |-> (lost_count == $past(lost_count) + LOST_W'(1)));

  assert_header_first_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(out_valid) |-> (out_data[OUT_W-1] && !out_last));

  assert_last_is_sample_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (out_valid && out_last) |-> !out_data[OUT_W-1]);

  assert_quiet_capture_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    capturing |-> !out_valid);
endmodule

bind hitwin_capture hwc_checker #(.OUT_W(OUT_W), .LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .lost_count(lost_count),
  .capturing(capturing)
);

// File: tb/hitwin_capture_tb.sv
module hitwin_capture_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  sample_in;
  logic        hit;
  logic [9:0]  toa_in;
  logic [4:0]  win_len;
  logic        out_valid;
  logic        out_ready;
  logic [16:0] out_data;
  logic        out_last;
  logic [7:0]  lost_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_lost = 0;
  logic [9:0] exp_s [32];

  always #2 clk = ~clk;

  hitwin_capture u_dut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .hit(hit), .toa_in(toa_in),
    .win_len(win_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .lost_count(lost_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int dec_len(input int cfg);
    return (cfg == 0) ? 32 : cfg;
  endfunction

  function automatic logic [16:0] hdr_word(input logic [9:0] t, input int n);
    return {1'b1, t, n[5:0]};
  endfunction

  function automatic logic [16:0] smp_word(input logic [9:0] s);
    return {7'd0, s};
  endfunction

  function automatic bit stray(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic note_stray(input bit h);
    if (h && exp_lost < 255) exp_lost++;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit = 1'b0;
      sample_in = 10'($urandom);
      chk(!out_valid, "R2 idle no output", out_valid, 0);
    end
  endtask

  // Caller is at a negedge with the block idle.
  task automatic run_event(input int cfg, input logic [9:0] t, input int hit_pct,
                           input int rdy_pct, input bit wiggle_len);
    int n;
    int idx;
    bit r;
    n = dec_len(cfg);
    win_len   = 5'(cfg);
    hit       = 1'b1;
    toa_in    = t;
    sample_in = 10'($urandom);
    exp_s[0]  = sample_in;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      chk(!out_valid, "R6 quiet during window", out_valid, 0);
      hit = stray(hit_pct);
      note_stray(hit);
      toa_in = 10'($urandom);
      if (wiggle_len) win_len = 5'($urandom);
      sample_in = 10'($urandom);
      exp_s[i] = sample_in;
    end
    @(negedge clk);
    hit = 1'b0;
    sample_in = 10'($urandom);
    chk(out_valid, "R6 auto readout starts", out_valid, 1);
    idx = 0;
    while (idx <= n) begin
      if (idx == 0) begin
        chk(out_data == hdr_word(t, n), "R4 header word", out_data, hdr_word(t, n));
        chk(!out_last, "R4 header not last", out_last, 0);
      end else begin
        chk(out_valid, "R7 valid held", out_valid, 1);
        chk(out_data == smp_word(exp_s[idx-1]), "R5 R2 R3 sample word",
            out_data, smp_word(exp_s[idx-1]));
        chk(out_last == (idx == n), "R5 last marker", out_last, idx == n);
      end
      r = stray(rdy_pct);
      out_ready = r;
      hit = stray(hit_pct);
      note_stray(hit);
      toa_in = 10'($urandom);
      sample_in = 10'($urandom);
      @(negedge clk);
      if (r) idx++;
    end
    out_ready = 1'b0;
    hit = 1'b0;
    chk(!out_valid, "R9 idle after final word", out_valid, 0);
    chk(lost_count == 8'(exp_lost), "R8 lost count", lost_count, exp_lost);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; hit = 1'b0; toa_in = '0; win_len = '0; out_ready = 1'b0;
    sample_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R1 reset valid low", out_valid, 0);
    chk(lost_count == 0, "R1 reset lost zero", lost_count, 0);
    idle_cycles(3);

    // Directed: one-sample and full-depth windows, mid-window length change.
    run_event(1, 10'h3a5, 0, 100, 1'b0);
    idle_cycles(2);
    run_event(0, 10'h155, 0, 70, 1'b0);
    idle_cycles(1);
    run_event(7, 10'h2c3, 0, 100, 1'b1);
    // R9: next hit in the very next cycle.
    run_event(4, 10'h0f0, 30, 50, 1'b0);
    run_event(31, 10'h001, 20, 40, 1'b1);

    // Random events.
    for (int e = 0; e < 40; e++) begin
      idle_cycles($urandom % 4);
      run_event($urandom % 32, 10'($urandom), $urandom % 40, 20 + ($urandom % 81),
                bit'($urandom % 2));
    end

    // R1: reset in mid-capture.
    @(negedge clk);
    win_len = 5'd20; hit = 1'b1; toa_in = 10'h111; sample_in = 10'($urandom);
    repeat (5) begin
      @(negedge clk);
      hit = 1'b1;
    end
    rst = 1'b1; hit = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_lost = 0;
    chk(!out_valid, "R1 mid-capture reset valid", out_valid, 0);
    chk(lost_count == 0, "R1 mid-capture reset lost", lost_count, 0);
    run_event(3, 10'h2aa, 0, 100, 1'b0);

    // R8: saturation under long stall with constant stray hits.
    run_event(0, 10'h3ff, 100, 5, 1'b0);
    chk(lost_count == 8'd255, "R8 lost saturates", lost_count, 255);
    run_event(2, 10'h044, 0, 100, 1'b0);
    chk(lost_count == 8'd255, "R8 lost held at max", lost_count, 255);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule